// File: doc/BRIEF.md
# Dual-Output Phase/Frequency Detector

This block compares the timing of a reference strobe with the timing of a feedback strobe. Both arrive in the system clock domain. It reports the result on two active-low error outputs: one for the reference side and one for the feedback side. A reference event pulls the reference-side output low. A feedback event pulls the feedback-side output low. Once both outputs are low, they are held together for a fixed minimum number of clocks and then both are released. The width of each low pulse therefore encodes how far one edge was ahead of the other. Circuitry outside the block combines the two pulse trains into a loop error signal.

When the feedback runs faster than the reference, or is ahead of it in phase, the error appears on the feedback-side output. The reference-side output shows only the short common pulse. The reverse holds when the feedback is slower or behind. When the two inputs are matched, both outputs carry only the brief common pulse.

A parameter selects how the inputs are read. In strobe mode, each input is a one-clock event pulse. In level mode, only a low-to-high transition of the input counts as an event.

Top module: `pfd_dual_out`

## Requirements
- R1: While reset (rst_n = 0) is applied, both phi_ref_n and phi_fb_n are 1 (high = idle).
- R2: An event on ref_in that is sampled at a clock edge while phi_ref_n is high drives phi_ref_n to 0 right after that edge, so it is visible one clock after the event cycle.
- R3: An event on fb_in that is sampled at a clock edge while phi_fb_n is high drives phi_fb_n to 0 right after that edge.
- R4: Once both outputs are low, they stay low together for exactly MIN_W clocks (default 3) and then both return high in the same cycle.
- R5: If the reference event comes d clocks before the feedback event, phi_ref_n is low for d+MIN_W clocks and phi_fb_n for MIN_W clocks. The mirror case swaps the two outputs.
- R6: Events on both inputs in the same cycle give both outputs a simultaneous low pulse of exactly MIN_W clocks.
- R7: A further event on an input whose output is already low has no effect. An output that is low while the other is high stays low.
- R8: An event sampled at the same edge that releases both outputs is discarded, and both outputs are high after that edge.
- R9: With feedback events at a higher rate than reference events, phi_fb_n accumulates more low time than phi_ref_n over the same window. The reverse holds with the rates swapped.
- R10: With EDGE_IN = 1, only a 0-to-1 transition of an input is an event. An input held high for many clocks does not produce a second pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference event (strobe, or level when EDGE_IN = 1) |
| fb_in | input | 1 | Feedback event (strobe, or level when EDGE_IN = 1) |
| phi_ref_n | output | 1 | Active-low reference-side error pulse |
| phi_fb_n | output | 1 | Active-low feedback-side error pulse |

## Verification
The hardest case to reach from the ports is an event that lands exactly on the edge where the common pulse ends. That event must be lost, and it cannot be seen directly: it only shows as the absence of a later pulse. A directed case places a second reference strobe MIN_W cycles after a coincident pair and checks that the reference output stays high afterwards. Dense random strobes on both inputs then hit this edge, and back-to-back overlaps, many more times. The bench compares every cycle against a cycle model for both input modes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   localparam int PFD_SIDES = 2;
   localparam int SIDE_REF  = 0;
   localparam int SIDE_FB   = 1;

   function automatic int pfd_cnt_bits(input int n);
      int b;
      b = $clog2(n + 1);
      return (b < 1) ? 1 : b;
   endfunction

endpackage

// File: rtl/pfd_edge_in.sv
module pfd_edge_in #(
   parameter int EDGE_IN = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic hit_o
);

   generate
      if (EDGE_IN == 0) begin : g_strobe
         assign hit_o = sig_i;
      end else begin : g_level
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sig_i;
         end
         assign hit_o = sig_i & ~prev_q;
      end
   endgenerate

endmodule

// File: rtl/pfd_state_flop.sv
module pfd_state_flop (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end

endmodule

// File: rtl/pfd_reset_timer.sv
module pfd_reset_timer
   import pfd_pkg::*;
#(
   parameter int MIN_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic both_i,
   output logic clr_o
);

   localparam int CNT_W = pfd_cnt_bits(MIN_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_W - 1);

   logic [CNT_W-1:0] cnt_q;

   assign clr_o = both_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (both_i && !clr_o) cnt_q <= cnt_q + 1'b1;
      else                       cnt_q <= '0;
   end

endmodule

// File: rtl/pfd_dual_out.sv
module pfd_dual_out
   import pfd_pkg::*;
#(
   parameter int MIN_W   = 3,
   parameter int EDGE_IN = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   input  logic fb_in,
   output logic phi_ref_n,
   output logic phi_fb_n
);

   generate
      if (MIN_W < 1) begin : g_bad_w
         $error("pfd_dual_out: MIN_W must be at least 1");
      end
      if (EDGE_IN != 0 && EDGE_IN != 1) begin : g_bad_mode
         $error("pfd_dual_out: EDGE_IN must be 0 or 1");
      end
   endgenerate

   logic [PFD_SIDES-1:0] raw_vec;
   logic [PFD_SIDES-1:0] hit_vec;
   logic [PFD_SIDES-1:0] st_vec;
   logic                 clr_all;

   assign raw_vec[SIDE_REF] = ref_in;
   assign raw_vec[SIDE_FB]  = fb_in;

   for (genvar s = 0; s < PFD_SIDES; s++) begin : g_side
      pfd_edge_in #(.EDGE_IN(EDGE_IN)) u_in (
         .clk  (clk),
         .rst_n(rst_n),
         .sig_i(raw_vec[s]),
         .hit_o(hit_vec[s])
      );
      pfd_state_flop u_st (
         .clk  (clk),
         .rst_n(rst_n),
         .set_i(hit_vec[s]),
         .clr_i(clr_all),
         .q_o  (st_vec[s])
      );
   end

   pfd_reset_timer #(.MIN_W(MIN_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .both_i(&st_vec),
      .clr_o (clr_all)
   );

   assign phi_ref_n = ~st_vec[SIDE_REF];
   assign phi_fb_n  = ~st_vec[SIDE_FB];

endmodule

// File: rtl/pfd_dual_out_chk.sv
module pfd_dual_out_chk #(
   parameter int MIN_W = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] hit,
   input logic       phi_ref_n,
   input logic       phi_fb_n
);

   logic        both_low;
   logic [15:0] run_q;

   assign both_low = !phi_ref_n && !phi_fb_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   run_q <= '0;
      else if (!both_low)           run_q <= '0;
      else if (run_q != 16'hffff)   run_q <= run_q + 1'b1;
   end

   // R2
   ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[0] && phi_ref_n) |=> !phi_ref_n);

   // R3
   fb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[1] && phi_fb_n) |=> !phi_fb_n);

   // R4
   coincide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (both_low && (32'(run_q) < MIN_W - 1)) |=> both_low);

   // R4
   coincide_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (both_low && (32'(run_q) == MIN_W - 1)) |=> (phi_ref_n && phi_fb_n));

   // R7
   ref_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phi_ref_n && phi_fb_n) |=> !phi_ref_n);

   // R7
   fb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!phi_fb_n && phi_ref_n) |=> !phi_fb_n);

endmodule

bind pfd_dual_out pfd_dual_out_chk #(.MIN_W(MIN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hit      (hit_vec),
   .phi_ref_n(phi_ref_n),
   .phi_fb_n (phi_fb_n)
);

// File: tb/test_pfd_dual_out.sv
module test_pfd_dual_out;

   localparam int MIN_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_s = 1'b0, fb_s = 1'b0, ref_l = 1'b0, fb_l = 1'b0;
   logic phr_s, phv_s, phr_l, phv_l;
   int   checks = 0, errors = 0;
   bit   done = 0;

   always #2 clk = ~clk;

   pfd_dual_out #(.MIN_W(MIN_W), .EDGE_IN(0)) i_pfd_dual_out (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_s), .fb_in(fb_s),
      .phi_ref_n(phr_s), .phi_fb_n(phv_s));

   pfd_dual_out #(.MIN_W(MIN_W), .EDGE_IN(1)) i_pfd_level (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_l), .fb_in(fb_l),
      .phi_ref_n(phr_l), .phi_fb_n(phv_l));

   // cycle model: event sets a side, after MIN_W coincident cycles both drop
   logic m_up = 0, m_dn = 0, l_up = 0, l_dn = 0, l_pr = 0, l_pv = 0;
   int   m_age = 0, l_age = 0;
   logic l_hr, l_hv;
   assign l_hr = ref_l & ~l_pr;
   assign l_hv = fb_l & ~l_pv;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_up <= 0; m_dn <= 0; m_age <= 0;
         l_up <= 0; l_dn <= 0; l_age <= 0; l_pr <= 0; l_pv <= 0;
      end else begin
         if (m_up && m_dn && m_age == MIN_W - 1) begin
            m_up <= 0; m_dn <= 0; m_age <= 0;
         end else begin
            m_up <= m_up | ref_s; m_dn <= m_dn | fb_s;
            m_age <= (m_up && m_dn) ? m_age + 1 : 0;
         end
         if (l_up && l_dn && l_age == MIN_W - 1) begin
            l_up <= 0; l_dn <= 0; l_age <= 0;
         end else begin
            l_up <= l_up | l_hr; l_dn <= l_dn | l_hv;
            l_age <= (l_up && l_dn) ? l_age + 1 : 0;
         end
         l_pr <= ref_l; l_pv <= fb_l;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 model ref strobe", phr_s, !m_up);
         chk("R5 model fb strobe", phv_s, !m_dn);
         chk("R10 model ref level", phr_l, !l_up);
         chk("R10 model fb level", phv_l, !l_dn);
      end
   end

   // per-cycle stimulus masks; counts low samples, both-low samples, first low
   task automatic run_case(input logic [63:0] rm, input logic [63:0] vm, input int len,
                           input bit lvl, output int lr, output int lv, output int lb,
                           output int fr, output int fv);
      lr = 0; lv = 0; lb = 0; fr = -1; fv = -1;
      for (int c = 0; c < len; c++) begin
         @(negedge clk);
         if (!(lvl ? phr_l : phr_s)) begin lr++; if (fr < 0) fr = c; end
         if (!(lvl ? phv_l : phv_s)) begin lv++; if (fv < 0) fv = c; end
         if (!(lvl ? phr_l : phr_s) && !(lvl ? phv_l : phv_s)) lb++;
         if (lvl) begin ref_l = rm[c]; fb_l = vm[c]; end
         else     begin ref_s = rm[c]; fb_s = vm[c]; end
      end
      @(negedge clk);
      ref_s = 0; fb_s = 0; ref_l = 0; fb_l = 0;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [63:0] bits2(input int a, input int b);
      logic [63:0] m = '0;
      if (a >= 0) m[a] = 1'b1;
      if (b >= 0) m[b] = 1'b1;
      return m;
   endfunction

   function automatic logic [63:0] span(input int a, input int b);
      logic [63:0] m = '0;
      for (int i = a; i <= b; i++) m[i] = 1'b1;
      return m;
   endfunction

   task automatic freq_case(input int pr, input int pv, output int lr, output int lv);
      lr = 0; lv = 0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (!phr_s) lr++;
         if (!phv_s) lv++;
         ref_s = (c % pr) == 1;
         fb_s  = (c % pv) == 1;
      end
      @(negedge clk);
      ref_s = 0; fb_s = 0;
      repeat (12) @(negedge clk);
      ref_s = 1; fb_s = 1;
      @(negedge clk);
      ref_s = 0; fb_s = 0;
      repeat (MIN_W + 4) @(negedge clk);
   endtask

   initial begin
      int lr, lv, lb, fr, fv;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1
      chk("R1 reset ref", phr_s, 1); chk("R1 reset fb", phv_s, 1);
      chk("R1 reset lvl ref", phr_l, 1); chk("R1 reset lvl fb", phv_l, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 latency and R5 lead
      run_case(bits2(2, -1), bits2(10, -1), 24, 0, lr, lv, lb, fr, fv);
      chk("R2 first ref low", fr, 3);
      chk("R5 lead ref width", lr, 8 + MIN_W);
      chk("R5 lead fb width", lv, MIN_W);
      // R3 latency
      run_case(bits2(12, -1), bits2(2, -1), 26, 0, lr, lv, lb, fr, fv);
      chk("R3 first fb low", fv, 3);
      chk("R5 lag fb width", lv, 10 + MIN_W);
      chk("R5 lag ref width", lr, MIN_W);
      // R5 short lead
      run_case(bits2(2, -1), bits2(7, -1), 20, 0, lr, lv, lb, fr, fv);
      chk("R5 d5 ref width", lr, 5 + MIN_W);
      chk("R5 d5 fb width", lv, MIN_W);
      // R6 in phase
      run_case(bits2(2, -1), bits2(2, -1), 16, 0, lr, lv, lb, fr, fv);
      chk("R6 ref width", lr, MIN_W);
      chk("R6 fb width", lv, MIN_W);
      chk("R4 coincident width", lb, MIN_W);
      // R7 repeat strobe ignored
      run_case(bits2(2, 3), bits2(6, -1), 20, 0, lr, lv, lb, fr, fv);
      chk("R7 ref width", lr, 4 + MIN_W);
      chk("R7 fb width", lv, MIN_W);
      // R8 strobe on release edge lost
      run_case(bits2(2, 2 + MIN_W), bits2(2, -1), 24, 0, lr, lv, lb, fr, fv);
      chk("R8 ref width", lr, MIN_W);
      chk("R8 ref idle after", phr_s, 1);
      // R9 frequency offset
      freq_case(10, 7, lr, lv);
      checks++;
      if (!(lv > lr)) begin errors++; $display("FAIL R9 fast fb: actual fb %0d ref %0d expected fb > ref", lv, lr); end
      freq_case(6, 9, lr, lv);
      checks++;
      if (!(lr > lv)) begin errors++; $display("FAIL R9 slow fb: actual ref %0d fb %0d expected ref > fb", lr, lv); end
      // R10 level mode, held-high inputs
      run_case(span(1, 30), span(4, 30), 40, 1, lr, lv, lb, fr, fv);
      chk("R10 level ref width", lr, 3 + MIN_W);
      chk("R10 level fb width", lv, MIN_W);

      // random strobes and levels against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         ref_s = ($urandom % 6) == 0;
         fb_s  = ($urandom % 6) == 0;
         if (($urandom % 5) == 0) ref_l = ~ref_l;
         if (($urandom % 5) == 0) fb_l = ~fb_l;
      end
      @(negedge clk);
      ref_s = 0; fb_s = 0;
      // R1 reset during activity
      ref_s = 1;
      @(negedge clk);
      ref_s = 0;
      rst_n = 1'b0;
      #1;
      chk("R1 mid reset ref", phr_s, 1);
      chk("R1 mid reset fb", phv_s, 1);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #700000;
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule